// File: doc/BRIEF.md
# Microcontroller Reduced-Power Mode Controller

This block sequences a small microcontroller core through three operating states: normal running, a light sleep, and a deep sleep. Software asks for a sleep state by pulsing one of two write strobes. The block then turns off the matching clock enables. In light sleep the CPU and DMA clocks stop and the peripheral clock keeps running. In deep sleep every clock stops, and so does the oscillator enable. The block also drives the values that the bus control pins must hold while the core sleeps.

All state changes happen on the edges of an internal clock, which is the input clock divided by two. The bench sees this divided clock on `div_clk`. The light sleep ends when any enabled interrupt request is high at a divided-clock edge. The deep sleep ends only through the asynchronous reset.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in RUN with `mode_o`=0. All four enables are 1, `pin_hold`=0 and `p0_float`=0. `div_clk` is 0 after reset.
- R2: `div_clk` toggles on every rising edge of `clk_in`. The mode changes only at a rising edge where `div_clk` was 1 just before the edge (a divided tick).
- R3: A pulse on `wr_idle` while in RUN is held pending until the next tick. At that tick the block enters IDLE, with cpu=0, dma=0, periph=1 and osc=1.
- R4: A pulse on `wr_pdown` while in RUN is held pending until the next tick. At that tick the block enters PDOWN, with all four enables 0.
- R5: If both requests are pending at the same tick, PDOWN wins.
- R6: In IDLE, a tick with a nonzero `irq_req & irq_en` returns the block to RUN. The idle request is cleared at that point, so the block does not enter IDLE again at later ticks. Requests whose enable bit is 0 have no effect.
- R7: Once in PDOWN, the block stays there whatever the interrupts or strobes do, until reset.
- R8: In IDLE, `pin_hold`=1 with `ale_val`=1 and `psen_val`=1. In PDOWN, `pin_hold`=1 with both values 0. In RUN, all three are 0.
- R9: In IDLE or PDOWN, `p0_float` equals `prog_ext`, so the port floats only when program memory is external. In RUN, `p0_float` is 0.
- R10: `mode_o` encodes the state as RUN=0, IDLE=1, PDOWN=2.
- R11: Strobes that arrive while in IDLE or PDOWN are ignored. They leave no pending request behind after the block returns to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock, before the divide-by-two |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_idle | input | 1 | Software strobe that requests IDLE |
| wr_pdown | input | 1 | Software strobe that requests PDOWN |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Interrupt enable mask |
| prog_ext | input | 1 | 1 when program memory is external |
| div_clk | output | 1 | Divided internal clock phase |
| mode_o | output | 2 | Current state |
| cpu_clk_en | output | 1 | CPU clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| pin_hold | output | 1 | Overrides the bus control pins with the values below |
| ale_val | output | 1 | Forced address latch enable level |
| psen_val | output | 1 | Forced program store enable level |
| p0_float | output | 1 | Floats the multiplexed address/data port |

## Verification
Two events can land on the same divided tick: a power-down request and an idle request, and an idle wake-up together with a strobe. The bench provokes both by driving sparse random strobes and interrupt patterns on every input cycle, and it adds directed cases where both strobes pulse together just before a tick. Each case is judged against a bench reference model. The model applies the PDOWN priority and treats strobes as ignored outside RUN.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pm_mode_e;

  // Clock enables, ordered {cpu, dma, periph, osc}
  function automatic logic [3:0] pm_enables(pm_mode_e m);
    case (m)
      MODE_IDLE:  pm_enables = 4'b0011;
      MODE_PDOWN: pm_enables = 4'b0000;
      default:    pm_enables = 4'b1111;
    endcase
  endfunction

  // Pin override, ordered {hold, ale, psen}
  function automatic logic [2:0] pm_pins(pm_mode_e m);
    case (m)
      MODE_IDLE:  pm_pins = 3'b111;
      MODE_PDOWN: pm_pins = 3'b100;
      default:    pm_pins = 3'b000;
    endcase
  endfunction

  function automatic logic pm_wake(logic [31:0] req, logic [31:0] en);
    pm_wake = |(req & en);
  endfunction
endpackage

// File: rtl/pwr_clkdiv.sv
module pwr_clkdiv (
  input  logic clk_in,
  input  logic rst_n,
  output logic phase,
  output logic tick
);
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign tick = phase;

  // R2
  toggle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwrmode_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     wr_idle,
  input  logic     wr_pdown,
  input  logic     wake,
  output pm_mode_e mode
);
  logic pend_idle_q, pend_pd_q;
  logic in_run, idle_req, pd_req;

  assign in_run   = (mode == MODE_RUN);
  assign idle_req = pend_idle_q | (in_run & wr_idle);
  assign pd_req   = pend_pd_q   | (in_run & wr_pdown);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= MODE_RUN;
      pend_idle_q <= 1'b0;
      pend_pd_q   <= 1'b0;
    end else begin
      if (in_run) begin
        pend_idle_q <= idle_req;
        pend_pd_q   <= pd_req;
      end
      if (tick) begin
        case (mode)
          MODE_RUN: begin
            if (pd_req)        mode <= MODE_PDOWN;
            else if (idle_req) mode <= MODE_IDLE;
          end
          MODE_IDLE: begin
            if (wake) begin
              mode        <= MODE_RUN;
              pend_idle_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  off_tick_stable_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !tick |=> $stable(mode));
  // R7
  pdown_sticky_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode == MODE_PDOWN) |=> (mode == MODE_PDOWN));
  // R5
  pdown_prio_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (tick && in_run && pd_req) |=> (mode == MODE_PDOWN));
  // R6
  wake_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (tick && mode == MODE_IDLE && wake) |=> (mode == MODE_RUN));
  // R6
  idle_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode == MODE_IDLE && !wake) |=> (mode == MODE_IDLE));
endmodule

// File: rtl/pwr_pin_ctrl.sv
module pwr_pin_ctrl
  import pwrmode_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  pm_mode_e mode,
  input  logic     prog_ext,
  output logic     pin_hold,
  output logic     ale_val,
  output logic     psen_val,
  output logic     p0_float
);
  logic [2:0] pins;

  always_comb begin
    pins     = pm_pins(mode);
    pin_hold = pins[2];
    ale_val  = pins[1];
    psen_val = pins[0];
    p0_float = (mode != MODE_RUN) & prog_ext;
  end

  // R8
  idle_pins_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode == MODE_IDLE) |-> (pin_hold && ale_val && psen_val));
  // R8
  pdown_pins_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode == MODE_PDOWN) |-> (pin_hold && !ale_val && !psen_val));
  // R9
  run_drive_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode == MODE_RUN) |-> (!p0_float && !pin_hold));
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic            clk_in,
  input  logic            rst_n,
  input  logic            wr_idle,
  input  logic            wr_pdown,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            prog_ext,
  output logic            div_clk,
  output logic [1:0]      mode_o,
  output logic            cpu_clk_en,
  output logic            dma_clk_en,
  output logic            per_clk_en,
  output logic            osc_en,
  output logic            pin_hold,
  output logic            ale_val,
  output logic            psen_val,
  output logic            p0_float
);
  localparam int PADW = 32 - NIRQ;

  logic       tick, wake;
  pm_mode_e   mode;
  logic [3:0] en_vec;

  assign wake = pm_wake({{PADW{1'b0}}, irq_req}, {{PADW{1'b0}}, irq_en});

  pwr_clkdiv u_div (
    .clk_in (clk_in), .rst_n (rst_n), .phase (div_clk), .tick (tick)
  );

  pwr_mode_fsm u_fsm (
    .clk_in (clk_in), .rst_n (rst_n), .tick (tick),
    .wr_idle (wr_idle), .wr_pdown (wr_pdown), .wake (wake), .mode (mode)
  );

  pwr_pin_ctrl u_pins (
    .clk_in (clk_in), .rst_n (rst_n), .mode (mode), .prog_ext (prog_ext),
    .pin_hold (pin_hold), .ale_val (ale_val), .psen_val (psen_val),
    .p0_float (p0_float)
  );

  always_comb begin
    en_vec     = pm_enables(mode);
    cpu_clk_en = en_vec[3];
    dma_clk_en = en_vec[2];
    per_clk_en = en_vec[1];
    osc_en     = en_vec[0];
    mode_o     = mode;
  end

  // R3
  idle_enables_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (!cpu_clk_en && !dma_clk_en && per_clk_en && osc_en));
  // R4
  pdown_enables_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode_o == 2'd2) |-> !(cpu_clk_en || dma_clk_en || per_clk_en || osc_en));
endmodule

// File: tb/pwrmode_ctrl_bench.sv
module pwrmode_ctrl_bench;
  localparam int NIRQ = 8;

  logic clk_in = 1'b0, rst_n = 1'b0;
  logic wr_idle = 1'b0, wr_pdown = 1'b0, prog_ext = 1'b0;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic div_clk, cpu_clk_en, dma_clk_en, per_clk_en, osc_en;
  logic pin_hold, ale_val, psen_val, p0_float;
  logic [1:0] mode_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_in = ~clk_in;

  pwrmode_ctrl #(.NIRQ(NIRQ)) u_pwrmode_ctrl (.*);

  // Reference model built from the requirements
  logic ph_m, pi_m, pp_m;
  logic [1:0] md_m;

  always @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ph_m <= 0; pi_m <= 0; pp_m <= 0; md_m <= 2'd0;            // R1
    end else begin
      logic pi, pp;
      pi = pi_m | (md_m == 2'd0 && wr_idle);                    // R11
      pp = pp_m | (md_m == 2'd0 && wr_pdown);
      if (md_m == 2'd0) begin pi_m <= pi; pp_m <= pp; end       // R3 R4
      ph_m <= ~ph_m;
      if (ph_m) begin                                           // R2
        if (md_m == 2'd0) begin
          if (pp) md_m <= 2'd2;                                 // R5
          else if (pi) md_m <= 2'd1;
        end else if (md_m == 2'd1 && (irq_req & irq_en) != 0) begin
          md_m <= 2'd0; pi_m <= 0;                              // R6
        end
      end                                                       // R7: PDOWN holds
    end
  end

  function automatic logic [3:0] exp_en(logic [1:0] m);
    return (m == 2'd0) ? 4'hF : (m == 2'd1) ? 4'h3 : 4'h0;
  endfunction

  function automatic logic [3:0] exp_pins(logic [1:0] m, logic ext);
    return (m == 2'd0) ? 4'h0 : (m == 2'd1) ? {3'b111, ext} : {3'b100, ext};
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_in) if (!done) begin
    chk("R2 div_clk", {3'b0, div_clk}, {3'b0, ph_m});
    chk("R10 mode", {2'b0, mode_o}, {2'b0, md_m});
    chk("R3/R4 enables", {cpu_clk_en, dma_clk_en, per_clk_en, osc_en}, exp_en(md_m));
    chk("R8/R9 pins", {pin_hold, ale_val, psen_val, p0_float}, exp_pins(md_m, prog_ext));
  end

  task automatic pulse(logic i, logic p);
    @(negedge clk_in); wr_idle = i; wr_pdown = p;
    @(negedge clk_in); wr_idle = 0; wr_pdown = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_in); rst_n = 0;
    repeat (2) @(negedge clk_in);
    rst_n = 1;                                                  // R1 checked on each cycle
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R5 both strobes together
    pulse(1, 1); repeat (4) @(negedge clk_in);
    // R7 interrupts ignored in PDOWN
    irq_req = '1; irq_en = '1; repeat (6) @(negedge clk_in);
    irq_req = '0; irq_en = '0;
    do_reset();
    // R3 idle, R6 masked irq does not wake, then enabled one does
    prog_ext = 1; pulse(1, 0); repeat (3) @(negedge clk_in);
    irq_req = 8'h10; irq_en = 8'h01; repeat (4) @(negedge clk_in);
    // R11 strobe in IDLE ignored
    pulse(0, 1); irq_en = 8'h10; repeat (4) @(negedge clk_in);
    irq_req = '0; irq_en = '0; repeat (6) @(negedge clk_in);
    // Random mix
    for (int n = 0; n < 30000; n++) begin
      @(negedge clk_in);
      wr_idle  = ($urandom % 12) == 0;
      wr_pdown = ($urandom % 60) == 0;
      irq_req  = (($urandom % 10) == 0) ? NIRQ'($urandom) : '0;
      irq_en   = NIRQ'($urandom);
      if (($urandom % 200) == 0) prog_ext = ~prog_ext;
      if (($urandom % 400) == 0) rst_n = 0;
      else rst_n = 1;
    end
    @(negedge clk_in);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule